// File: doc/BRIEF.md
# Predicated Vector Element Stepper

This block walks the element positions of one vector instruction when both the operand side and the result side carry their own predicate mask. It holds a source position and a destination position, each running from zero up to the active vector length. On each side, positions whose mask bit is clear are passed over without spending a cycle, so the position shown is always the next element that really takes part. The two sides search independently of each other.

Either side may instead run in zeroing mode. A zeroing side does not pass over anything: it visits every position below the vector length. Where its mask bit is clear, the operand is replaced by zero (source side) or the result is written as zero (destination side). For each presented element the block raises exactly one flag per side to say what the datapath should do. It also gates the condition-result update, which must not happen while destination zeroing is in force.

A start strobe reloads both positions to zero and an advance strobe consumes the current element. The instruction is complete when the source position equals the vector length. It then stays complete, ignoring advances, until the next start. A single-mask option takes both masks from the destination mask input.

Top module: `vec_elem_stepper`

## Requirements
- R1: With source zeroing off, `src_step_o` shows the lowest position p, with p at or above the stored source position and p below `vl_i`, whose source mask bit (bit p of the selected mask) is 1. If there is no such position it shows `vl_i`. `src_rd_o` is 1 while an element is presented.
- R2: With destination zeroing off, `dst_step_o` follows the same rule using the destination mask and its own stored position, independent of the source side. `dst_wr_o` is 1 while `dst_step_o` is below `vl_i`.
- R3: `done_o` is 1 in the same cycle in which the source position equals `vl_i`. Then `src_step_o` equals `vl_i` and all four element flags are 0.
- R4: With source zeroing on, the source side visits every position below `vl_i` in turn. It raises `src_rd_o` where the mask bit is 1 and `src_zsub_o` where it is 0.
- R5: With destination zeroing on, the destination side visits every position below `vl_i`. It raises `dst_wr_o` where the mask bit is 1 and `dst_wz_o` where it is 0. With `vl_i`=2, mask 0b01 and zeroing on, element 0 is written and element 1 is zeroed.
- R6: With `single_pred_i`=1, `dst_mask_i` supplies both sides and `src_mask_i` has no effect.
- R7: An `adv_i` pulse while not done moves each side's stored position to one past its presented step, unless that side is already at `vl_i`. The next search starts from there.
- R8: While done, `adv_i` has no effect on either step. A `start_i` pulse at any time reloads both stored positions to 0 for the next cycle.
- R9: `rc_en_o` is `rc_req_i` while `dst_wr_o` is 1 and destination zeroing is off. Otherwise it is 0.
- R10: After reset and before the first `start_i`, both steps read 0, `done_o` is 1 and all element flags are 0.
- R11: With `vl_i`=0, or with no source mask bit set below `vl_i`, `done_o` is 1 in the cycle right after `start_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Reload both positions to zero |
| adv_i | input | 1 | Consume the presented element |
| src_mask_i | input | 64 | Source predicate, bit p for element p |
| dst_mask_i | input | 64 | Destination predicate, bit p for element p |
| single_pred_i | input | 1 | Take both masks from dst_mask_i |
| vl_i | input | 7 | Vector length, 0 to 64 |
| src_zero_i | input | 1 | Source zeroing mode |
| dst_zero_i | input | 1 | Destination zeroing mode |
| rc_req_i | input | 1 | Instruction asks for a condition-result update |
| src_step_o | output | 7 | Presented source position |
| dst_step_o | output | 7 | Presented destination position |
| src_rd_o | output | 1 | Read the source operand register |
| src_zsub_o | output | 1 | Substitute zero for the source operand |
| dst_wr_o | output | 1 | Write the computed result |
| dst_wz_o | output | 1 | Write zero as the result |
| rc_en_o | output | 1 | Perform the condition-result update |
| done_o | output | 1 | Instruction complete |

## Verification
The step-progress and hold assertions assume that the masks, `vl_i` and the zeroing flags stay constant between a start and the next start. The properties are written so that a change in those inputs releases them rather than making them fail. `vl_i` is assumed never to exceed the mask width. The stimulus changes the instruction inputs only in the cycle of a start pulse and keeps every vector length at 8 or below. Advance pulses are sent both while elements remain and after completion, so both the progress and the hold properties are exercised.

// File: rtl/vstep_pkg.sv
package vstep_pkg;
  parameter int unsigned STEP_W = 7;
  parameter int unsigned MAX_VL = 64;
  typedef logic [STEP_W-1:0] step_t;
  typedef logic [MAX_VL-1:0] mask_t;
endpackage

// File: rtl/vstep_scan.sv
module vstep_scan
  import vstep_pkg::*;
(
  input  mask_t mask_i,
  input  step_t from_i,
  input  step_t vl_i,
  output step_t pos_o
);
  logic [MAX_VL-1:0] cand;

  genvar g;
  generate
    for (g = 0; g < MAX_VL; g++) begin : g_cand
      assign cand[g] = mask_i[g] && (step_t'(g) >= from_i) && (step_t'(g) < vl_i);
    end
  endgenerate

  // lowest qualifying position wins; vl when none
  always_comb begin
    pos_o = vl_i;
    for (int i = MAX_VL - 1; i >= 0; i--) begin
      if (cand[i]) pos_o = step_t'(i);
    end
  end
endmodule

// File: rtl/vstep_lane.sv
module vstep_lane
  import vstep_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  load_i,
  input  logic  adv_i,
  input  logic  active_i,
  input  mask_t mask_i,
  input  step_t vl_i,
  input  logic  zero_i,
  output step_t step_o,
  output logic  end_o,
  output logic  bit_o
);
  step_t raw_q;
  step_t found;
  step_t eff;

  vstep_scan u_scan (
    .mask_i (mask_i),
    .from_i (raw_q),
    .vl_i   (vl_i),
    .pos_o  (found)
  );

  // zeroing side never skips
  assign eff    = zero_i ? ((raw_q >= vl_i) ? vl_i : raw_q) : found;
  assign step_o = eff;
  assign end_o  = (eff == vl_i);
  assign bit_o  = !end_o && |(mask_i & (mask_t'(1) << eff));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                raw_q <= '0;
    else if (load_i)            raw_q <= '0;
    else if (adv_i && !end_o)   raw_q <= eff + step_t'(1);
  end

  a_r1_lands_on_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !zero_i && !end_o) |-> bit_o);

  a_r7_progress: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !end_o && !load_i) |=>
      (step_o > $past(step_o)) || !$stable(mask_i) || !$stable(vl_i) || !$stable(zero_i));

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (end_o && !load_i) |=>
      (step_o == $past(step_o)) || !$stable(mask_i) || !$stable(vl_i) || !$stable(zero_i));

  a_r8_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (raw_q == '0));
endmodule

// File: rtl/vec_elem_stepper.sv
module vec_elem_stepper
  import vstep_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              adv_i,
  input  logic [MAX_VL-1:0] src_mask_i,
  input  logic [MAX_VL-1:0] dst_mask_i,
  input  logic              single_pred_i,
  input  logic [STEP_W-1:0] vl_i,
  input  logic              src_zero_i,
  input  logic              dst_zero_i,
  input  logic              rc_req_i,
  output logic [STEP_W-1:0] src_step_o,
  output logic [STEP_W-1:0] dst_step_o,
  output logic              src_rd_o,
  output logic              src_zsub_o,
  output logic              dst_wr_o,
  output logic              dst_wz_o,
  output logic              rc_en_o,
  output logic              done_o
);
  logic  active_q;
  mask_t s_mask;
  step_t s_step, d_step;
  logic  s_end, d_end, s_bit, d_bit;
  logic  go, step_adv;

  assign s_mask   = single_pred_i ? dst_mask_i : src_mask_i;
  assign go       = active_q && !s_end;
  assign step_adv = adv_i && go && !start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      active_q <= 1'b0;
    else if (start_i) active_q <= 1'b1;
  end

  vstep_lane u_src (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (start_i),
    .adv_i    (step_adv),
    .active_i (active_q),
    .mask_i   (s_mask),
    .vl_i     (vl_i),
    .zero_i   (src_zero_i),
    .step_o   (s_step),
    .end_o    (s_end),
    .bit_o    (s_bit)
  );

  vstep_lane u_dst (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (start_i),
    .adv_i    (step_adv),
    .active_i (active_q),
    .mask_i   (dst_mask_i),
    .vl_i     (vl_i),
    .zero_i   (dst_zero_i),
    .step_o   (d_step),
    .end_o    (d_end),
    .bit_o    (d_bit)
  );

  assign src_step_o = active_q ? s_step : '0;
  assign dst_step_o = active_q ? d_step : '0;
  assign done_o     = !go;
  assign src_rd_o   = go && s_bit;
  assign src_zsub_o = go && !s_bit;
  assign dst_wr_o   = go && !d_end && d_bit;
  assign dst_wz_o   = go && !d_end && !d_bit;
  assign rc_en_o    = rc_req_i && dst_wr_o && !dst_zero_i;

  a_r3_done_at_vl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && active_q) |-> (src_step_o == vl_i));

  a_r3_no_flags_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !(src_rd_o || src_zsub_o || dst_wr_o || dst_wz_o));

  a_r9_rc_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dst_zero_i |-> !rc_en_o);

  a_r4_src_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({src_rd_o, src_zsub_o}) && $onehot0({dst_wr_o, dst_wz_o}));

  a_r1_no_zsub_skip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !src_zero_i |-> !src_zsub_o);
endmodule

// File: tb/vec_elem_stepper_tb_top.sv
`timescale 1ns/1ps
module vec_elem_stepper_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, adv = 1'b0;
  logic [63:0] smask = '0, dmask = '0;
  logic        single = 1'b0, sz = 1'b0, dz = 1'b0, rcq = 1'b1;
  logic [6:0]  vl = '0;
  logic [6:0]  s_step, d_step;
  logic        s_rd, s_zs, d_wr, d_wz, rc_en, done;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  vec_elem_stepper dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .adv_i(adv),
    .src_mask_i(smask), .dst_mask_i(dmask), .single_pred_i(single),
    .vl_i(vl), .src_zero_i(sz), .dst_zero_i(dz), .rc_req_i(rcq),
    .src_step_o(s_step), .dst_step_o(d_step), .src_rd_o(s_rd),
    .src_zsub_o(s_zs), .dst_wr_o(d_wr), .dst_wz_o(d_wz),
    .rc_en_o(rc_en), .done_o(done)
  );

  // {src_mask, dst_mask, vl, sz dz single 0, expected element count}
  localparam logic [35:0] VEC [9] = '{
    {8'hA5, 8'hFF, 8'd8, 4'b0000, 8'd4},  // R1 skipping
    {8'hFF, 8'h0F, 8'd6, 4'b0000, 8'd6},  // R2 dest ends first
    {8'h03, 8'h01, 8'd2, 4'b0100, 8'd2},  // R5 dest zeroing example
    {8'h05, 8'hFF, 8'd4, 4'b1000, 8'd4},  // R4 source zeroing
    {8'hFF, 8'h0A, 8'd5, 4'b0010, 8'd2},  // R6 single mask
    {8'hFF, 8'hFF, 8'd0, 4'b0000, 8'd0},  // R11 vl zero
    {8'h00, 8'hFF, 8'd8, 4'b0000, 8'd0},  // R11 empty mask
    {8'h80, 8'h80, 8'd7, 4'b0000, 8'd0},  // R11 bit beyond vl
    {8'h0C, 8'h30, 8'd8, 4'b1100, 8'd8}   // R4 R5 both zeroing
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int nxt(input logic [63:0] m, input int from, input int n, input bit z);
    if (z) return (from >= n) ? n : from;
    for (int i = from; i < n; i++) if (m[i]) return i;
    return n;
  endfunction

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic pulse_adv();
    adv = 1'b1;
    @(negedge clk); adv = 1'b0;
  endtask

  initial begin
    #(100000 * 5);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 idle after reset
    chk("R10 src_step", s_step, 0);
    chk("R10 dst_step", d_step, 0);
    chk("R10 done", done, 1);
    chk("R10 flags", {s_rd, s_zs, d_wr, d_wz}, 0);

    for (int e = 0; e < 9; e++) begin
      logic [63:0] sm, dm;
      int n, cnt, sr, dr, s, d, exp_cnt;
      bit vsz, vdz, vsg;
      string rs, rd;
      sm = 64'(VEC[e][35:28]); dm = 64'(VEC[e][27:20]);
      n = int'(VEC[e][19:12]);
      vsz = VEC[e][11]; vdz = VEC[e][10]; vsg = VEC[e][9];
      exp_cnt = int'(VEC[e][7:0]);
      @(negedge clk);
      smask = sm; dmask = dm; vl = 7'(n); sz = vsz; dz = vdz; single = vsg;
      start = 1'b1;
      @(negedge clk); start = 1'b0;
      if (vsg) sm = dm;
      rs = vsg ? "R6" : (vsz ? "R4" : "R1");
      rd = vdz ? "R5" : "R2";
      sr = 0; dr = 0; cnt = 0;
      while (cnt < 20) begin
        s = nxt(sm, sr, n, vsz);
        d = nxt(dm, dr, n, vdz);
        if (s == n) break;
        chk({rs, " src_step"}, s_step, s);
        chk({rd, " dst_step"}, d_step, d);
        chk({rs, " src_rd"}, s_rd, sm[s]);
        chk({rs, " src_zsub"}, s_zs, !sm[s]);
        chk({rd, " dst_wr"}, d_wr, (d < n) && dm[d]);
        chk({rd, " dst_wz"}, d_wz, (d < n) && !dm[d]);
        chk("R9 rc_en", rc_en, (d < n) && dm[d] && !vdz);
        chk("R3 done low", done, 0);
        pulse_adv();  // R7
        sr = s + 1;
        dr = (d >= n) ? d : d + 1;
        cnt++;
      end
      chk((exp_cnt == 0) ? "R11 done" : "R3 done", done, 1);
      chk("R3 src_step at vl", s_step, n);
      chk("R3 flags low", {s_rd, s_zs, d_wr, d_wz}, 0);
      chk("R7 element count", cnt, exp_cnt);
      // R8 advance ignored when done
      pulse_adv();
      chk("R8 src hold", s_step, n);
      chk("R8 dst hold", d_step, nxt(dm, dr, n, vdz));
    end

    // R8 restart mid-instruction
    @(negedge clk);
    smask = 64'hF0; dmask = 64'hFF; vl = 7'd8; sz = 0; dz = 0; single = 0;
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R1 first set", s_step, 4);
    pulse_adv(); pulse_adv();
    chk("R7 src moved", s_step, 6);
    chk("R7 dst moved", d_step, 2);
    pulse_start();
    chk("R8 restart src", s_step, 4);
    chk("R8 restart dst", d_step, 0);
    // R9 rc request low
    rcq = 1'b0;
    @(negedge clk);
    chk("R9 rc off", rc_en, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule